// File: doc/BRIEF.md
# Transmit DMA Channel Controller

This block is the send half of a full-duplex packet network interface. Software programs four registers: a negated word count, a word-aligned buffer address, a start delay and a control word. Setting the enable bit starts a transfer. The engine first counts down the delay. It then fetches 16-bit words from memory one at a time over a request/grant read port. Each word goes unchanged to a serial-side word sink over a valid/ready handshake.

A transfer can end in one of three ways. If every word is delivered, the done flag is raised and the done interrupt fires when interrupts are enabled. If the sink asks for a word before one is ready (an underrun), the transfer ends with done and error both set. If the line reports a collision, the transfer stops at once and the error flag is set. A collision raises a separate collision interrupt and does not set done, because retry and backoff are left to software. The header's source address is never touched; the words are sent exactly as they sit in memory.

Top module: `tx_dma_ctrl`

## Requirements
- R1: After reset every register reads zero, and mem_req_o, sink_valid_o, irq_done_o and irq_coll_o are low.
- R2: Register index 0 holds the count in bits 9:0. Index 1 holds the byte address in bits 15:1, and bit 0 reads 0. Index 2 is control: bit 15 error, bit 7 done, bit 6 interrupt enable, bit 0 enable. Index 3 holds the delay in bits 7:0. Unused bits read zero, and the error and done bits cannot be written.
- R3: While enable is set, writes to the count, address and delay registers are ignored. A control write at that time changes only the interrupt enable bit.
- R4: A control write with bit 0 set while idle clears done, error and the pending collision. The first read request rises exactly D+1 clock cycles after the write edge, where D is the delay value.
- R5: Reads start at the programmed address and step by 2 for each delivered word. mem_req_o stays high until granted unless the transfer ends, and it is never high together with sink_valid_o.
- R6: With the count loaded as the two's complement of N, exactly N words reach the sink in memory order and unchanged. sink_data_o holds steady while a word waits. Afterwards the count reads 0 and the address reads start+2N.
- R7: When the last word is accepted, done is set, enable clears, and irq_done_o equals done AND interrupt enable.
- R8: A count of zero at start performs no memory reads and finishes with done set D+1 cycles after the start write.
- R9: A collision while enabled ends the transfer at that clock edge: there is no request or valid on the next cycle, error is set, done stays clear, and irq_coll_o follows the interrupt enable while irq_done_o stays low.
- R10: After the first word has been accepted, sink_ready_i high while the engine is still fetching is an underrun. It sets error and done and clears enable, leaving the count advanced only for the words already delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register index |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data of the indexed register |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory byte address |
| mem_gnt_i | input | 1 | Grant; read data valid this cycle |
| mem_rdata_i | input | 16 | Memory read data |
| sink_valid_o | output | 1 | Word available to the sink |
| sink_data_o | output | 16 | Word to the sink |
| sink_ready_i | input | 1 | Sink takes or wants a word |
| coll_i | input | 1 | Collision detected on the line |
| irq_done_o | output | 1 | Transfer complete interrupt |
| irq_coll_o | output | 1 | Collision interrupt |

## Verification
The assertions assume that memory returns data in the same cycle as the grant. They also assume that the sink only raises ready in the fetch phase when it means to report an underrun. The random stimulus keeps to these rules: grant is given only while a request is visible, and in normal runs ready is driven only while valid is high. Underruns are produced on purpose by forcing ready high in one test. Collisions are injected through the bench's own responder, which drops grant and ready in that cycle so that no handshake is counted twice.

// File: rtl/tx_dma_pkg.sv
package tx_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_FETCH = 2'd2,
    ST_HOLD  = 2'd3
  } tx_state_e;

  localparam logic [1:0] REG_CNT  = 2'd0;
  localparam logic [1:0] REG_ADR  = 2'd1;
  localparam logic [1:0] REG_CTL  = 2'd2;
  localparam logic [1:0] REG_DLY  = 2'd3;

  localparam int unsigned CTL_ERR_BIT  = 15;
  localparam int unsigned CTL_DONE_BIT = 7;
  localparam int unsigned CTL_IE_BIT   = 6;
  localparam int unsigned CTL_EN_BIT   = 0;
endpackage

// File: rtl/tx_dma_regs.sv
module tx_dma_regs
  import tx_dma_pkg::*;
#(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 16,
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             adv_i,
  input  logic             fin_ok_i,
  input  logic             fin_urun_i,
  input  logic             fin_coll_i,
  output logic             start_o,
  output logic             en_o,
  output logic             ie_o,
  output logic             done_o,
  output logic             err_o,
  output logic             coll_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [AW-2:0]    adr_o,
  output logic [DLY_W-1:0] dly_o
);
  localparam int unsigned BA_W = AW - 1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [BA_W-1:0]  ADR_ONE = BA_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [BA_W-1:0]  adr_q;
  logic [DLY_W-1:0] dly_q;
  logic             en_q, ie_q, done_q, err_q, coll_q;
  logic             ctl_wr, idle_wr;

  assign ctl_wr  = we_i && (addr_i == REG_CTL);
  assign idle_wr = we_i && !en_q;
  assign start_o = ctl_wr && wdata_i[CTL_EN_BIT] && !en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      adr_q <= '0;
      dly_q <= '0;
    end else if (idle_wr) begin
      case (addr_i)
        REG_CNT: cnt_q <= wdata_i[CNT_W-1:0];
        REG_ADR: adr_q <= wdata_i[AW-1:1];
        REG_DLY: dly_q <= wdata_i[DLY_W-1:0];
        default: ;
      endcase
    end else if (adv_i) begin
      cnt_q <= cnt_q + CNT_ONE;
      adr_q <= adr_q + ADR_ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      coll_q <= 1'b0;
    end else begin
      if (ctl_wr) ie_q <= wdata_i[CTL_IE_BIT];
      if (start_o) begin
        en_q   <= 1'b1;
        done_q <= 1'b0;
        err_q  <= 1'b0;
        coll_q <= 1'b0;
      end else if (fin_coll_i) begin
        en_q   <= 1'b0;
        err_q  <= 1'b1;
        coll_q <= 1'b1;
      end else if (fin_urun_i) begin
        en_q   <= 1'b0;
        err_q  <= 1'b1;
        done_q <= 1'b1;
      end else if (fin_ok_i) begin
        en_q   <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CNT: rdata_o[CNT_W-1:0] = cnt_q;
      REG_ADR: rdata_o[AW-1:1]    = adr_q;
      REG_CTL: begin
        rdata_o[CTL_ERR_BIT]  = err_q;
        rdata_o[CTL_DONE_BIT] = done_q;
        rdata_o[CTL_IE_BIT]   = ie_q;
        rdata_o[CTL_EN_BIT]   = en_q;
      end
      default: rdata_o[DLY_W-1:0] = dly_q;
    endcase
  end

  assign en_o   = en_q;
  assign ie_o   = ie_q;
  assign done_o = done_q;
  assign err_o  = err_q;
  assign coll_o = coll_q;
  assign cnt_o  = cnt_q;
  assign adr_o  = adr_q;
  assign dly_o  = dly_q;
endmodule

// File: rtl/tx_dma_seq.sv
module tx_dma_seq
  import tx_dma_pkg::*;
#(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 16,
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [AW-2:0]    adr_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             coll_i,
  input  logic             mem_gnt_i,
  input  logic [DW-1:0]    mem_rdata_i,
  input  logic             sink_ready_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic             sink_valid_o,
  output logic [DW-1:0]    sink_data_o,
  output logic             adv_o,
  output logic             fin_ok_o,
  output logic             fin_urun_o,
  output logic             fin_coll_o
);
  localparam logic [DLY_W-1:0] DLY_ONE = DLY_W'(1);

  tx_state_e        state_q;
  logic [DLY_W-1:0] dcnt_q;
  logic [DW-1:0]    buf_q;
  logic             stream_q;
  logic             busy, cnt_last, cnt_zero, wait_end;

  assign busy     = (state_q != ST_IDLE);
  assign cnt_last = &cnt_i;
  assign cnt_zero = (cnt_i == '0);
  assign wait_end = (state_q == ST_WAIT) && (dcnt_q == '0);

  assign fin_coll_o = busy && coll_i;
  assign adv_o      = (state_q == ST_HOLD) && sink_ready_i && !coll_i;
  assign fin_urun_o = (state_q == ST_FETCH) && stream_q && sink_ready_i && !coll_i;
  assign fin_ok_o   = !coll_i && ((wait_end && cnt_zero) || (adv_o && cnt_last));

  assign mem_req_o    = (state_q == ST_FETCH);
  assign mem_addr_o   = {adr_i, 1'b0};
  assign sink_valid_o = (state_q == ST_HOLD);
  assign sink_data_o  = buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      dcnt_q   <= '0;
      buf_q    <= '0;
      stream_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q  <= ST_WAIT;
          dcnt_q   <= dly_i;
          stream_q <= 1'b0;
        end
        ST_WAIT: begin
          if (coll_i)          state_q <= ST_IDLE;
          else if (wait_end)   state_q <= cnt_zero ? ST_IDLE : ST_FETCH;
          else                 dcnt_q  <= dcnt_q - DLY_ONE;
        end
        ST_FETCH: begin
          if (coll_i || fin_urun_o) state_q <= ST_IDLE;
          else if (mem_gnt_i) begin
            buf_q   <= mem_rdata_i;
            state_q <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (coll_i) state_q <= ST_IDLE;
          else if (sink_ready_i) begin
            stream_q <= 1'b1;
            state_q  <= cnt_last ? ST_IDLE : ST_FETCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_dma_irq.sv
module tx_dma_irq (
  input  logic ie_i,
  input  logic done_i,
  input  logic coll_i,
  output logic irq_done_o,
  output logic irq_coll_o
);
  assign irq_done_o = ie_i && done_i;
  assign irq_coll_o = ie_i && coll_i;
endmodule

// File: rtl/tx_dma_ctrl.sv
module tx_dma_ctrl #(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 16,
  parameter int unsigned DLY_W = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_gnt_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          sink_valid_o,
  output logic [DW-1:0] sink_data_o,
  input  logic          sink_ready_i,
  input  logic          coll_i,
  output logic          irq_done_o,
  output logic          irq_coll_o
);
  logic             start, adv, fin_ok, fin_urun, fin_coll;
  logic             csr_en, csr_ie, csr_done, csr_err, csr_coll;
  logic [CNT_W-1:0] cnt;
  logic [AW-2:0]    adr;
  logic [DLY_W-1:0] dly;

  tx_dma_regs #(.CNT_W(CNT_W), .AW(AW), .DW(DW), .DLY_W(DLY_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .adv_i      (adv),
    .fin_ok_i   (fin_ok),
    .fin_urun_i (fin_urun),
    .fin_coll_i (fin_coll),
    .start_o    (start),
    .en_o       (csr_en),
    .ie_o       (csr_ie),
    .done_o     (csr_done),
    .err_o      (csr_err),
    .coll_o     (csr_coll),
    .cnt_o      (cnt),
    .adr_o      (adr),
    .dly_o      (dly)
  );

  tx_dma_seq #(.CNT_W(CNT_W), .AW(AW), .DW(DW), .DLY_W(DLY_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .cnt_i        (cnt),
    .adr_i        (adr),
    .dly_i        (dly),
    .coll_i       (coll_i),
    .mem_gnt_i    (mem_gnt_i),
    .mem_rdata_i  (mem_rdata_i),
    .sink_ready_i (sink_ready_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .sink_valid_o (sink_valid_o),
    .sink_data_o  (sink_data_o),
    .adv_o        (adv),
    .fin_ok_o     (fin_ok),
    .fin_urun_o   (fin_urun),
    .fin_coll_o   (fin_coll)
  );

  tx_dma_irq u_irq (
    .ie_i       (csr_ie),
    .done_i     (csr_done),
    .coll_i     (csr_coll),
    .irq_done_o (irq_done_o),
    .irq_coll_o (irq_coll_o)
  );
endmodule

// File: rtl/tx_dma_chk.sv
module tx_dma_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          done_i,
  input logic          err_i,
  input logic          mem_req_i,
  input logic          mem_gnt_i,
  input logic          sink_valid_i,
  input logic          sink_ready_i,
  input logic [DW-1:0] sink_data_i,
  input logic          coll_i,
  input logic          irq_done_i,
  input logic          irq_coll_i
);
  // R5
  req_valid_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_i && sink_valid_i));

  // R5
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && !mem_gnt_i |=> mem_req_i || !en_i);

  // R6
  data_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sink_valid_i && !sink_ready_i |=> !sink_valid_i || $stable(sink_data_i));

  // R7
  done_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> $fell(en_i));

  // R9
  coll_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_i && en_i |=> !en_i && err_i && !done_i && !mem_req_i && !sink_valid_i);

  // R9
  irq_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_done_i && irq_coll_i));

  // R3
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !mem_req_i && !sink_valid_i);
endmodule

bind tx_dma_ctrl tx_dma_chk #(.DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (csr_en),
  .done_i       (csr_done),
  .err_i        (csr_err),
  .mem_req_i    (mem_req_o),
  .mem_gnt_i    (mem_gnt_i),
  .sink_valid_i (sink_valid_o),
  .sink_ready_i (sink_ready_i),
  .sink_data_i  (sink_data_o),
  .coll_i       (coll_i),
  .irq_done_i   (irq_done_o),
  .irq_coll_i   (irq_coll_o)
);

// File: tb/sim_tx_dma_ctrl.sv
module sim_tx_dma_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        mem_req_o;
  logic [15:0] mem_addr_o;
  logic        mem_gnt_i = 1'b0;
  logic [15:0] mem_rdata_i = '0;
  logic        sink_valid_o;
  logic [15:0] sink_data_o;
  logic        sink_ready_i = 1'b0;
  logic        coll_i = 1'b0;
  logic        irq_done_o, irq_coll_o;

  int checks = 0, errors = 0, cycles = 0;
  int n_got = 0, addr_bad = 0, data_bad = 0, n_req = 0;
  logic [15:0] exp_addr = '0, exp_rd = '0;
  bit force_rdy = 1'b0, coll_req = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_dma_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .mem_req_o(mem_req_o),
    .mem_addr_o(mem_addr_o), .mem_gnt_i(mem_gnt_i), .mem_rdata_i(mem_rdata_i),
    .sink_valid_o(sink_valid_o), .sink_data_o(sink_data_o),
    .sink_ready_i(sink_ready_i), .coll_i(coll_i), .irq_done_o(irq_done_o),
    .irq_coll_o(irq_coll_o)
  );

  function automatic logic [15:0] mem_word(input logic [15:0] a);
    return (a * 16'h9E37) ^ 16'h5A0F ^ {a[7:0], a[15:8]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // memory and sink responder
  always @(negedge clk) begin
    coll_i = coll_req;
    coll_req = 1'b0;
    if (coll_i) begin
      mem_gnt_i = 1'b0;
      sink_ready_i = 1'b0;
    end else begin
      mem_gnt_i = mem_req_o && ($urandom % 4 != 0);
      mem_rdata_i = mem_word(mem_addr_o);
      if (mem_gnt_i) begin
        if (mem_addr_o != exp_addr) addr_bad++;
        exp_addr = exp_addr + 16'd2;
        n_req++;
      end
      sink_ready_i = force_rdy ? 1'b1 : (sink_valid_o && ($urandom % 3 != 0));
      if (sink_valid_o && sink_ready_i) begin
        if (sink_data_o != mem_word(exp_rd)) data_bad++;
        exp_rd = exp_rd + 16'd2;
        n_got++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      finish_sim();
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic wait_end(output logic [15:0] ctl);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk); #1;
      rd(2'd2, ctl);
      if (ctl[7] || ctl[15]) break;
    end
  endtask

  task automatic setup(input int n, input logic [15:0] ba, input int d);
    exp_addr = ba; exp_rd = ba; n_got = 0; n_req = 0; addr_bad = 0; data_bad = 0;
    wr(2'd0, 16'((-n) & 'h3FF));
    wr(2'd1, ba);
    wr(2'd3, 16'(d));
  endtask

  task automatic run_xfer(input int n, input logic [15:0] ba, input int d, input bit ie);
    int k;
    logic [15:0] v;
    setup(n, ba, d);
    wr(2'd2, ie ? 16'h0041 : 16'h0001);
    k = 0;
    while (!mem_req_o && k < 1000) begin @(negedge clk); k++; end
    chk(k == d + 1, "R4", "start delay cycles", k, d + 1);
    wait_end(v);
    chk(n_got == n, "R6", "word count delivered", n_got, n);
    chk(data_bad == 0, "R6", "data mismatches", data_bad, 0);
    chk(addr_bad == 0, "R5", "address mismatches", addr_bad, 0);
    chk(v == (ie ? 16'h00C0 : 16'h0080), "R7", "control after done", v, ie ? 'hC0 : 'h80);
    chk(irq_done_o == ie, "R7", "irq_done_o", irq_done_o, ie);
    rd(2'd0, v);
    chk(v == 16'h0000, "R6", "count after done", v, 0);
    rd(2'd1, v);
    chk(v == 16'(ba + 2 * n), "R6", "address after done", v, 16'(ba + 2 * n));
  endtask

  initial begin
    logic [15:0] v;
    int k;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v == 16'h0, "R1", "register after reset", v, 0);
    end
    chk({mem_req_o, sink_valid_o, irq_done_o, irq_coll_o} == 4'b0, "R1", "outputs after reset",
        {mem_req_o, sink_valid_o, irq_done_o, irq_coll_o}, 0);

    // R2 field layout and unused bits
    wr(2'd0, 16'hFFFF); rd(2'd0, v); chk(v == 16'h03FF, "R2", "count field", v, 'h3FF);
    wr(2'd1, 16'hFFFF); rd(2'd1, v); chk(v == 16'hFFFE, "R2", "address field", v, 'hFFFE);
    wr(2'd3, 16'hFFFF); rd(2'd3, v); chk(v == 16'h00FF, "R2", "delay field", v, 'hFF);
    wr(2'd2, 16'hFFFE); rd(2'd2, v); chk(v == 16'h0040, "R2", "control field", v, 'h40);
    wr(2'd2, 16'h0000);

    // directed single word, zero delay
    run_xfer(1, 16'h0100, 0, 1'b1);
    // random transfers
    for (int t = 0; t < 8; t++)
      run_xfer(1 + int'($urandom % 40), 16'($urandom) & 16'hFFFE, int'($urandom % 21), 1'($urandom));
    // maximum delay
    run_xfer(3, 16'hFFFC, 255, 1'b0);

    // R8 zero count
    setup(0, 16'h2000, 5);
    wr(2'd2, 16'h0041);
    k = 0;
    do begin #1; rd(2'd2, v); if (v[7]) break; @(negedge clk); k++; end while (k < 100);
    chk(k == 6, "R8", "zero count finish cycles", k, 6);
    chk(n_req == 0, "R8", "reads with zero count", n_req, 0);

    // R3 writes while busy
    setup(30, 16'h4000, 50);
    wr(2'd2, 16'h0001);
    wr(2'd0, 16'h0111); wr(2'd1, 16'h1234); wr(2'd3, 16'h0007);
    wr(2'd2, 16'h8080 | 16'h0040);
    rd(2'd0, v); chk(v == 16'h03E2, "R3", "count kept while busy", v, 'h3E2);
    rd(2'd1, v); chk(v == 16'h4000, "R3", "address kept while busy", v, 'h4000);
    rd(2'd3, v); chk(v == 16'h0032, "R3", "delay kept while busy", v, 'h32);
    rd(2'd2, v); chk(v == 16'h0041, "R3", "control while busy", v, 'h41);
    wait_end(v);
    chk(n_got == 30 && data_bad == 0, "R3", "transfer after busy writes", n_got, 30);

    // R9 collision mid-transfer
    setup(20, 16'h6000, 3);
    wr(2'd2, 16'h0041);
    while (n_got < 3) begin @(negedge clk); #1; end
    coll_req = 1'b1;
    @(negedge clk); @(negedge clk); #1;
    chk(!mem_req_o && !sink_valid_o, "R9", "activity after collision",
        {mem_req_o, sink_valid_o}, 0);
    rd(2'd2, v); chk(v == 16'h8040, "R9", "control after collision", v, 'h8040);
    chk(irq_coll_o == 1'b1, "R9", "irq_coll_o", irq_coll_o, 1);
    chk(irq_done_o == 1'b0, "R9", "irq_done_o on collision", irq_done_o, 0);
    // R4 restart clears collision state
    run_xfer(4, 16'h0800, 2, 1'b1);
    chk(irq_coll_o == 1'b0, "R4", "irq_coll_o after restart", irq_coll_o, 0);

    // R10 underrun
    setup(8, 16'h7000, 1);
    force_rdy = 1'b1;
    wr(2'd2, 16'h0001);
    wait_end(v);
    force_rdy = 1'b0;
    chk(v == 16'h8080, "R10", "control after underrun", v, 'h8080);
    chk(n_got == 1, "R10", "words before underrun", n_got, 1);
    rd(2'd0, v); chk(v == 16'h03F9, "R10", "count after underrun", v, 'h3F9);

    repeat (3) @(negedge clk);
    finish_sim();
  end
endmodule